// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI flash master from a faster parent clock. A single 32-bit configuration word carries a source-select bit and three 6-bit fields. One field sets the last count of the period. A second sets the last count of the high phase. A third holds a divide value that this block reads only in its alternative build variant. A phase counter runs while the transfer engine holds the enable high, and the serial clock level follows from comparing that counter with the high-phase limit.

Next to the clock level, the block produces two registered one-cycle strobes. Each strobe is high in the same cycle as the clock transition it marks, so a shift engine can launch or capture data on them without detecting edges itself. With the enable low, the clock rests low (mode 0 idle) and the counter is held at its first phase. A new enable therefore always begins with a full high phase.

The fields are read every cycle. A new configuration takes effect on the period that is already running, and the counter wraps at once if it has already passed the new end count. Software normally programs the period field to n, the high field to ((n+1)/2)-1 and the divide field to n. This gives a period of n+1 parent cycles, with n from 1 to 63.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, sclk_o, rise_o and fall_o are all 0.
- R2: With configuration bit 31 = 1, the clock period is L+1 parent cycles, where L is bits 5:0 of the configuration word. An L of 0 is treated as 1, so the divider covers parent/2 down to parent/64.
- R3: With bit 31 = 1, sclk_o is high for min(H, L-1)+1 cycles at the start of each period and low for the rest, where H is bits 11:6. The usual setting H = ((L+1)/2)-1 gives the duty nearest 50%.
- R4: With bit 31 = 0, the clock is a fixed divide-by-2 (one cycle high, one low), whatever the field values.
- R5: In the default build, bits 17:12 (the divide field) and bits 30:18 have no effect on the output.
- R6: With enable low, sclk_o is low from the next cycle on. The first cycle after enable is sampled high begins a new period with sclk_o high.
- R7: rise_o is high for exactly the one cycle in which sclk_o has just gone 0 to 1, and fall_o for exactly the cycle in which it has gone 1 to 0. This includes the fall caused by dropping the enable during the high phase.
- R8: A configuration change applies in the running period. If the counter is already at or past the new end count, it wraps to the first phase on the next cycle.
- R9: Dropping the enable in the cycle where a rising edge would otherwise occur suppresses that edge: sclk_o stays low and neither strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Clock configuration word (bit 31 source, 17:12 divide, 11:6 high count, 5:0 period count) |
| en_i | input | 1 | Run enable from the transfer engine |
| sclk_o | output | 1 | Serial clock level |
| rise_o | output | 1 | One-cycle strobe on the serial clock's rising edge |
| fall_o | output | 1 | One-cycle strobe on the serial clock's falling edge |

## Verification
The risky coincidences are the enable being withdrawn in the very cycle the counter wraps and a rising edge is due, and a reconfiguration arriving while the counter already sits past the new end count. The first is provoked by dropping the enable right after the last low cycle of a four-cycle period. It is judged by requiring sclk_o, rise_o and fall_o all to stay 0 afterwards. The second shrinks the period from 64 to 4 cycles forty cycles into a run. The bench then expects one low cycle with no strobe, followed by the new four-cycle pattern from its first phase, checked cycle by cycle against a waveform derived from the requirements.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

   // Source selection carried by one bit of the configuration word
   typedef enum logic {
      SRC_FIXED_DIV2 = 1'b0,
      SRC_PROGRAMMED = 1'b1
   } spiclk_src_e;

   // Default field placement inside the configuration word
   localparam int DEF_CFG_W   = 32;
   localparam int DEF_CNT_W   = 6;
   localparam int DEF_SRC_BIT = 31;
   localparam int DEF_DIV_LSB = 12;
   localparam int DEF_HI_LSB  = 6;
   localparam int DEF_LO_LSB  = 0;

endpackage

// File: rtl/spiclk_cfg_decode.sv
module spiclk_cfg_decode #(
   parameter int CFG_W   = spiclk_pkg::DEF_CFG_W,
   parameter int CNT_W   = spiclk_pkg::DEF_CNT_W,
   parameter int SRC_BIT = spiclk_pkg::DEF_SRC_BIT,
   parameter int DIV_LSB = spiclk_pkg::DEF_DIV_LSB,
   parameter int HI_LSB  = spiclk_pkg::DEF_HI_LSB,
   parameter int LO_LSB  = spiclk_pkg::DEF_LO_LSB,
   parameter bit TERM_FROM_DIV = 1'b0
) (
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CNT_W-1:0] last_o,
   output logic [CNT_W-1:0] hi_last_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0]        term_raw;
   logic [CNT_W-1:0]        hi_raw;
   logic [CNT_W-1:0]        term_safe;
   spiclk_pkg::spiclk_src_e src;
   logic                    unused_cfg_bits;

   // Which field ends the period is a build-time choice
   generate
      if (TERM_FROM_DIV) begin : g_term_div
         assign term_raw = cfg_i[DIV_LSB +: CNT_W];
      end else begin : g_term_low
         assign term_raw = cfg_i[LO_LSB +: CNT_W];
      end
   endgenerate

   assign hi_raw          = cfg_i[HI_LSB +: CNT_W];
   assign src             = spiclk_pkg::spiclk_src_e'(cfg_i[SRC_BIT]);
   assign unused_cfg_bits = ^cfg_i;

   always_comb begin
      term_safe = (term_raw < ONE) ? ONE : term_raw;
      if (src == spiclk_pkg::SRC_PROGRAMMED) begin
         last_o    = term_safe;
         // keep at least one low cycle in every period
         hi_last_o = (hi_raw >= term_safe) ? (term_safe - ONE) : hi_raw;
      end else begin
         last_o    = ONE;
         hi_last_o = '0;
      end
   end

endmodule

// File: rtl/spiclk_phase_cnt.sv
module spiclk_phase_cnt #(
   parameter int CNT_W = spiclk_pkg::DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] last_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q >= last_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen #(
   parameter int CNT_W = spiclk_pkg::DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] hi_last_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic want_high;
   logic sclk_q, rise_q, fall_q;

   assign want_high = run_i && (cnt_i <= hi_last_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         sclk_q <= want_high;
         rise_q <= want_high && !sclk_q;
         fall_q <= !want_high && sclk_q;
      end
   end

   assign sclk_o = sclk_q;
   assign rise_o = rise_q;
   assign fall_o = fall_q;

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
   parameter int CFG_W   = spiclk_pkg::DEF_CFG_W,
   parameter int CNT_W   = spiclk_pkg::DEF_CNT_W,
   parameter int SRC_BIT = spiclk_pkg::DEF_SRC_BIT,
   parameter int DIV_LSB = spiclk_pkg::DEF_DIV_LSB,
   parameter int HI_LSB  = spiclk_pkg::DEF_HI_LSB,
   parameter int LO_LSB  = spiclk_pkg::DEF_LO_LSB,
   parameter bit TERM_FROM_DIV = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             en_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   localparam int FIELD_TOP = CNT_W - 1;

   // Elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_err_cnt_w
         $error("spi_sclk_divider: CNT_W must be at least 2");
      end
      if (SRC_BIT >= CFG_W) begin : g_err_src
         $error("spi_sclk_divider: SRC_BIT outside configuration word");
      end
      if (DIV_LSB + FIELD_TOP >= CFG_W || HI_LSB + FIELD_TOP >= CFG_W ||
          LO_LSB + FIELD_TOP >= CFG_W) begin : g_err_field
         $error("spi_sclk_divider: a count field does not fit the configuration word");
      end
   endgenerate

   logic [CNT_W-1:0] last_w;
   logic [CNT_W-1:0] hi_last_w;
   logic [CNT_W-1:0] cnt_w;

   spiclk_cfg_decode #(
      .CFG_W(CFG_W), .CNT_W(CNT_W), .SRC_BIT(SRC_BIT), .DIV_LSB(DIV_LSB),
      .HI_LSB(HI_LSB), .LO_LSB(LO_LSB), .TERM_FROM_DIV(TERM_FROM_DIV)
   ) i_decode (
      .cfg_i     (cfg_i),
      .last_o    (last_w),
      .hi_last_o (hi_last_w)
   );

   spiclk_phase_cnt #(.CNT_W(CNT_W)) i_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (en_i),
      .last_i (last_w),
      .cnt_o  (cnt_w)
   );

   spiclk_edge_gen #(.CNT_W(CNT_W)) i_edges (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (en_i),
      .cnt_i     (cnt_w),
      .hi_last_i (hi_last_w),
      .sclk_o    (sclk_o),
      .rise_o    (rise_o),
      .fall_o    (fall_o)
   );

endmodule

// File: rtl/spiclk_checker.sv
module spiclk_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic en_i,
   input logic sclk_o,
   input logic rise_o,
   input logic fall_o
);

   a_r7_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (sclk_o && !$past(sclk_o)));

   a_r7_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> (!sclk_o && $past(sclk_o)));

   a_r7_rise_not_missed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sclk_o) |-> rise_o);

   a_r7_fall_not_missed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sclk_o) |-> fall_o);

   // R6, and R9 as a consequence: no high level follows a cycle with enable low
   a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !sclk_o);

   a_r6_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_i) |=> sclk_o);

endmodule

bind spi_sclk_divider spiclk_checker i_spiclk_checker (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_i   (en_i),
   .sclk_o (sclk_o),
   .rise_o (rise_o),
   .fall_o (fall_o)
);

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;
   localparam int CLK_PERIOD = 10;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg   = '0;
   logic        en    = 1'b0;
   logic        sclk, rise, fall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sclk_divider i_spi_sclk_divider (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .cfg_i  (cfg),
      .en_i   (en),
      .sclk_o (sclk),
      .rise_o (rise),
      .fall_o (fall)
   );

   function automatic logic [31:0] mk_cfg(input bit src, input int div, input int hi,
                                          input int lo, input logic [12:0] fill);
      return {src, fill, 6'(div), 6'(hi), 6'(lo)};
   endfunction

   task automatic check3(input string req, input string what,
                         input logic es, input logic er, input logic ef);
      checks++;
      if (sclk !== es || rise !== er || fall !== ef) begin
         errors++;
         $display("FAIL %s %s: sclk/rise/fall=%b%b%b expected %b%b%b",
                  req, what, sclk, rise, fall, es, er, ef);
      end
   endtask

   // Compares ncyc consecutive samples against the waveform the requirements give
   task automatic check_wave(input string req, input int per, input int hi_last, input int ncyc);
      int   bad = 0;
      logic es, er, ef;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         es = ((c % per) <= hi_last);
         er = ((c % per) == 0);
         ef = ((c % per) == hi_last + 1);
         if (bad == 0 && (sclk !== es || rise !== er || fall !== ef)) begin
            bad = 1;
            $display("FAIL %s period %0d cycle %0d: sclk/rise/fall=%b%b%b expected %b%b%b",
                     req, per, c, sclk, rise, fall, es, er, ef);
         end
      end
      checks++;
      errors += bad;
   endtask

   task automatic start(input logic [31:0] c);
      @(negedge clk);
      cfg = c;
      en  = 1'b1;
   endtask

   task automatic stop();
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check3("R1", "during reset", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check3("R1", "after reset, enable low", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_programmed(input int n);
      start(mk_cfg(1'b1, n, ((n + 1) / 2) - 1, n, 13'h0));
      check_wave((n == 1) ? "R2" : "R3", n + 1, ((n + 1) / 2) - 1, 3 * (n + 1));
      stop();
   endtask

   task automatic t_clamps();
      // R2: period field 0 behaves as 1
      start(mk_cfg(1'b1, 0, 0, 0, 13'h0));
      check_wave("R2", 2, 0, 8);
      stop();
      // R3: high count past the period end is limited to one cycle short
      start(mk_cfg(1'b1, 5, 9, 5, 13'h0));
      check_wave("R3", 6, 4, 18);
      stop();
   endtask

   task automatic t_source_fixed();
      start(mk_cfg(1'b0, 9, 5, 20, 13'h0));
      check_wave("R4", 2, 0, 10);
      stop();
   endtask

   task automatic t_ignored_bits();
      start(mk_cfg(1'b1, 42, 1, 4, 13'h1abc));
      check_wave("R5", 5, 1, 15);
      stop();
   endtask

   task automatic t_disable();
      start(mk_cfg(1'b1, 7, 3, 7, 13'h0));
      check_wave("R6", 8, 3, 2);
      en = 1'b0;
      @(negedge clk);
      check3("R7", "fall forced by disable", 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      check3("R6", "idle after disable", 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check3("R6", "still idle", 1'b0, 1'b0, 1'b0);
      // R9: disable just when the rising edge is due
      start(mk_cfg(1'b1, 3, 1, 3, 13'h0));
      check_wave("R9", 4, 1, 4);
      en = 1'b0;
      @(negedge clk);
      check3("R9", "edge due at disable", 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check3("R9", "no late edge", 1'b0, 1'b0, 1'b0);
      // R6: re-enable restarts from the first phase
      start(mk_cfg(1'b1, 3, 1, 3, 13'h0));
      check_wave("R6", 4, 1, 8);
      stop();
   endtask

   task automatic t_reconfig();
      start(mk_cfg(1'b1, 63, 31, 63, 13'h0));
      check_wave("R2", 64, 31, 40);
      cfg = mk_cfg(1'b1, 3, 1, 3, 13'h0);
      @(negedge clk);
      check3("R8", "wrap after shrinking period", 1'b0, 1'b0, 1'b0);
      check_wave("R8", 4, 1, 12);
      stop();
   endtask

   initial begin
      t_reset();
      t_programmed(1);
      t_programmed(4);
      t_programmed(7);
      t_programmed(63);
      t_clamps();
      t_source_fixed();
      t_ignored_bits();
      t_disable();
      t_reconfig();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule